// File: doc/BRIEF.md
# Framebuffer pixel format unpacker

This block sits between a framebuffer fetch engine and a palette or colour stage. It takes 32-bit words of raw framebuffer data on one valid/ready stream and emits one pixel per transfer on a second valid/ready stream. Each pixel is either an 8-bit palette index, flagged by `out_is_index`, or a 24-bit direct colour packed as `{R[7:0], G[7:0], B[7:0]}`. The unpacking follows a 3-bit depth code, a byte-order control, a pixel-order control and a red/blue swap control. On the base controller variant (`REVISED = 0`), a 2-bit board mux input also chooses the layout used in 16 bpp mode.

All controls are sampled when a word is accepted. Every pixel of that word is decoded with that snapshot, so the controls may change freely while pixels are pending. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the pixel on `out_data`/`out_is_index` is held unchanged. A new word is accepted (`in_ready` high) only when no pixel is pending, or when the last pixel of the current word leaves in the same cycle.

A separate combinational path reports how many source bytes one display line occupies, given a column count and the current depth code.

Top module: `fb_unpack`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Depth codes 0, 1, 2 and 3 give 32, 16, 8 and 4 pixels per word of 1, 2, 4 and 8 bits. Each such pixel has `out_is_index` = 1, the value in `out_data[7:0]` and zeros in `out_data[23:8]`. Codes 4, 6 and 7 give 2 pixels per word, each taken from a 16-bit slot, and code 5 gives 1 pixel.
- R3: With both order controls low, pixel k of a word is taken from bits [k*b + b-1 : k*b], where b is the slot width, so the first pixel comes from the least significant bits.
- R4: With `cfg_pix_be` high and `cfg_byte_be` low, the pixel order is reversed: the first pixel comes from the most significant slot of the word.
- R5: With `cfg_byte_be` high, the four bytes of the word are reversed first (byte 3 becomes byte 0), and the pixels are then taken LSB-first. In this mode `cfg_pix_be` has no effect.
- R6: At depth 5 (32 bpp), red is bits [7:0], green is bits [15:8] and blue is bits [23:16]; bits [31:24] are ignored.
- R7: With `cfg_bgr` high, red and blue of every direct-colour pixel are swapped, except in the layout that R8 exempts.
- R8: On the base variant at depth 4, the mux input selects the layout. Mux 1 gives 5:5:5 with red in [4:0], green in [9:5] and blue in [14:10]; bit 15 is ignored. Mux 0 and mux 2 give 5:6:5 with red in [4:0], green in [10:5] and blue in [15:11]. Mux 3 gives 5:6:5 with blue in [4:0] and red in [15:11], and `cfg_bgr` is ignored. A 5-bit channel c expands to {c,000} and a 6-bit channel to {c,00}.
- R9: On the revised variant, the mux input is ignored. Depth 4 gives the mux-1 5:5:5 layout, depth 6 gives the mux-0 5:6:5 layout, and depth 7 gives 4:4:4 with red in [3:0], green in [7:4] and blue in [11:8], each expanded to {c,0000}.
- R10: On the base variant, a word accepted at depth 6 or 7 is consumed and produces no pixel.
- R11: While `out_valid` is high and `out_ready` is low, the output pixel stays stable. `in_ready` is high only when no pixel is pending, or when the last pending pixel is being taken.
- R12: `line_bytes` is the column count shifted right by 3, 2 or 1 at depths 0, 1 and 2. It equals the column count at depth 3, twice the column count at depths 4, 6 and 7, and four times the column count at depth 5.
- R13: Each word's pixels are decoded with the control values present when that word was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 3 | Depth code |
| cfg_byte_be | input | 1 | Byte-order control (reverse bytes) |
| cfg_pix_be | input | 1 | Pixel-order control (MSB-first) |
| cfg_bgr | input | 1 | Red/blue swap |
| cfg_mux | input | 2 | Board mux for base-variant 16 bpp layout |
| line_cols | input | COLS_W | Columns per line |
| line_bytes | output | COLS_W+2 | Source bytes per line |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Word accepted when high with in_valid |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream accepts pixel |
| out_data | output | 24 | Index in [7:0], or {R,G,B} |
| out_is_index | output | 1 | Pixel is a palette index |

## Verification
The hardest situation to reach from the ports is a word being accepted in the same cycle that the last pixel of the previous word leaves, while the control inputs change around that edge. In that situation the new snapshot must replace the old one exactly at the boundary. The stimulus reaches it in long runs in which `in_valid` and `out_ready` are each held high about three cycles in four and every control input is redrawn every cycle. Many words therefore chain back to back under varying control values, and a queue model records the values seen at each acceptance.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  typedef enum logic [2:0] {
    D1 = 3'd0, D2 = 3'd1, D4 = 3'd2, D8 = 3'd3,
    D16 = 3'd4, D32 = 3'd5, D565 = 3'd6, D12 = 3'd7
  } depth_e;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  function automatic logic [CNT_W-1:0] pix_per_word(depth_e d);
    case (d)
      D1:      return CNT_W'(32);
      D2:      return CNT_W'(16);
      D4:      return CNT_W'(8);
      D8:      return CNT_W'(4);
      D32:     return CNT_W'(1);
      default: return CNT_W'(2);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] pix_bits(depth_e d);
    case (d)
      D1:      return CNT_W'(1);
      D2:      return CNT_W'(2);
      D4:      return CNT_W'(4);
      D8:      return CNT_W'(8);
      D32:     return CNT_W'(32);
      default: return CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/fbu_line_calc.sv
module fbu_line_calc
  import fbu_pkg::*;
#(
  parameter int COLS_W = 12
) (
  input  depth_e              depth,
  input  logic [COLS_W-1:0]   cols,
  output logic [COLS_W+1:0]   bytes_per_line
);
  localparam int OUT_W = COLS_W + 2;

  always_comb begin
    case (depth)
      D1:      bytes_per_line = OUT_W'(cols >> 3);
      D2:      bytes_per_line = OUT_W'(cols >> 2);
      D4:      bytes_per_line = OUT_W'(cols >> 1);
      D8:      bytes_per_line = OUT_W'(cols);
      D32:     bytes_per_line = {cols, 2'b00};
      default: bytes_per_line = {1'b0, cols, 1'b0};
    endcase
  end
endmodule

// File: rtl/fbu_slicer.sv
module fbu_slicer
  import fbu_pkg::*;
#(
  parameter bit REVISED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  depth_e            cfg_depth,
  input  logic              cfg_byte_be,
  input  logic              cfg_pix_be,
  input  logic              cfg_bgr,
  input  logic [1:0]        cfg_mux,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [23:0]       pix_raw,
  output depth_e            pix_depth,
  output logic              pix_bgr,
  output logic [1:0]        pix_mux
);
  localparam int SH_W = CNT_W + 1;

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;
  logic              msbf_q;
  logic              accept;
  logic [CNT_W-1:0]  load_cnt;
  logic [WORD_W-1:0] swapped;
  logic [SH_W-1:0]   slot_w;
  logic [SH_W-1:0]   shamt;
  logic [23:0]       mask;

  assign out_valid = (left_q != '0);
  assign in_ready  = (left_q == '0) || (left_q == CNT_W'(1) && out_ready);
  assign accept    = in_valid && in_ready;

  // Reserved depth codes on the base variant consume a word with no output.
  generate
    if (REVISED) begin : g_rev
      assign load_cnt = pix_per_word(cfg_depth);
    end else begin : g_base
      assign load_cnt = (cfg_depth == D565 || cfg_depth == D12) ? '0
                                                                : pix_per_word(cfg_depth);
    end
  endgenerate

  assign swapped = cfg_byte_be ? {in_word[7:0], in_word[15:8], in_word[23:16], in_word[31:24]}
                               : in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      left_q    <= '0;
      idx_q     <= '0;
      msbf_q    <= 1'b0;
      pix_depth <= D1;
      pix_bgr   <= 1'b0;
      pix_mux   <= 2'b00;
    end else if (accept) begin
      word_q    <= swapped;
      left_q    <= load_cnt;
      idx_q     <= '0;
      msbf_q    <= cfg_pix_be && !cfg_byte_be;
      pix_depth <= cfg_depth;
      pix_bgr   <= cfg_bgr;
      pix_mux   <= cfg_mux;
    end else if (out_valid && out_ready) begin
      left_q <= left_q - CNT_W'(1);
      idx_q  <= idx_q + CNT_W'(1);
    end
  end

  assign slot_w = SH_W'(pix_bits(pix_depth));
  assign shamt  = msbf_q ? SH_W'(WORD_W) - slot_w * SH_W'(idx_q + CNT_W'(1))
                         : slot_w * SH_W'(idx_q);

  always_comb begin
    case (pix_depth)
      D1:      mask = 24'h000001;
      D2:      mask = 24'h000003;
      D4:      mask = 24'h00000f;
      D8:      mask = 24'h0000ff;
      D32:     mask = 24'hffffff;
      default: mask = 24'h00ffff;
    endcase
  end

  assign pix_raw = 24'(word_q >> shamt) & mask;

  // R11
  no_overload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q > CNT_W'(1)) |-> !in_ready);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (left_q <= CNT_W'(32)));
endmodule

// File: rtl/fbu_colour.sv
module fbu_colour
  import fbu_pkg::*;
#(
  parameter bit REVISED = 1'b0
) (
  input  logic [23:0] raw,
  input  depth_e      depth,
  input  logic        bgr,
  input  logic [1:0]  mux,
  output logic [23:0] data,
  output logic        is_index
);
  typedef enum logic [2:0] { L_IDX, L_5551, L_565, L_565B, L_444, L_888 } layout_e;

  layout_e    lay;
  logic [7:0] r, g, b;

  always_comb begin
    case (depth)
      D1, D2, D4, D8: lay = L_IDX;
      D32:            lay = L_888;
      D16: begin
        if (REVISED)         lay = L_5551;
        else if (mux == 2'd1) lay = L_5551;
        else if (mux == 2'd3) lay = L_565B;
        else                  lay = L_565;
      end
      D565:    lay = L_565;
      default: lay = L_444;
    endcase
  end

  always_comb begin
    case (lay)
      L_5551: begin r = {raw[4:0], 3'b0};  g = {raw[9:5], 3'b0};  b = {raw[14:10], 3'b0}; end
      L_565:  begin r = {raw[4:0], 3'b0};  g = {raw[10:5], 2'b0}; b = {raw[15:11], 3'b0}; end
      L_565B: begin b = {raw[4:0], 3'b0};  g = {raw[10:5], 2'b0}; r = {raw[15:11], 3'b0}; end
      L_444:  begin r = {raw[3:0], 4'b0};  g = {raw[7:4], 4'b0};  b = {raw[11:8], 4'b0};  end
      L_888:  begin r = raw[7:0];          g = raw[15:8];         b = raw[23:16];         end
      default: begin r = 8'h00; g = 8'h00; b = raw[7:0]; end
    endcase
  end

  always_comb begin
    is_index = (lay == L_IDX);
    if (is_index)                   data = {16'h0000, b};
    else if (bgr && lay != L_565B)  data = {b, g, r};
    else                            data = {r, g, b};
  end
endmodule

// File: rtl/fb_unpack.sv
module fb_unpack
  import fbu_pkg::*;
#(
  parameter bit REVISED = 1'b0,
  parameter int COLS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_byte_be,
  input  logic              cfg_pix_be,
  input  logic              cfg_bgr,
  input  logic [1:0]        cfg_mux,
  input  logic [COLS_W-1:0] line_cols,
  output logic [COLS_W+1:0] line_bytes,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [23:0]       out_data,
  output logic              out_is_index
);
  depth_e      depth_in;
  logic [23:0] pix_raw;
  depth_e      pix_depth;
  logic        pix_bgr;
  logic [1:0]  pix_mux;

  assign depth_in = depth_e'(cfg_depth);

  fbu_line_calc #(.COLS_W(COLS_W)) u_line (
    .depth(depth_in), .cols(line_cols), .bytes_per_line(line_bytes)
  );

  fbu_slicer #(.REVISED(REVISED)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .cfg_depth(depth_in), .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be),
    .cfg_bgr(cfg_bgr), .cfg_mux(cfg_mux),
    .out_ready(out_ready), .out_valid(out_valid),
    .pix_raw(pix_raw), .pix_depth(pix_depth), .pix_bgr(pix_bgr), .pix_mux(pix_mux)
  );

  fbu_colour #(.REVISED(REVISED)) u_col (
    .raw(pix_raw), .depth(pix_depth), .bgr(pix_bgr), .mux(pix_mux),
    .data(out_data), .is_index(out_is_index)
  );

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_index)));
  // R2
  index_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_index) |-> (out_data[23:8] == 16'h0000));
  // R10
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!REVISED && in_valid && in_ready && cfg_depth[2:1] == 2'b11) |=> !out_valid);
  // R12
  line_8bpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd3) |-> (line_bytes == (COLS_W+2)'(line_cols)));
endmodule

// File: tb/fb_unpack_test.sv
module fb_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  dep = 3'd0;
  logic        bb = 1'b0, bp = 1'b0, bg = 1'b0;
  logic [1:0]  mx = 2'd0;
  logic [11:0] cols = '0;
  logic        in_valid0 = 1'b0, in_valid1 = 1'b0;
  logic [31:0] word = '0;
  logic        out_ready = 1'b0;
  logic        in_ready0, in_ready1, out_valid0, out_valid1, idx0, idx1;
  logic [23:0] data0, data1;
  logic [13:0] lb0, lb1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [24:0] q[$];
  string       tq[$];

  always #2 clk = ~clk;

  fb_unpack #(.REVISED(1'b0), .COLS_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(dep), .cfg_byte_be(bb), .cfg_pix_be(bp),
    .cfg_bgr(bg), .cfg_mux(mx), .line_cols(cols), .line_bytes(lb0),
    .in_valid(in_valid0), .in_ready(in_ready0), .in_word(word),
    .out_valid(out_valid0), .out_ready(out_ready), .out_data(data0), .out_is_index(idx0));

  fb_unpack #(.REVISED(1'b1), .COLS_W(12)) uut_rev (
    .clk(clk), .rst_n(rst_n), .cfg_depth(dep), .cfg_byte_be(bb), .cfg_pix_be(bp),
    .cfg_bgr(bg), .cfg_mux(mx), .line_cols(cols), .line_bytes(lb1),
    .in_valid(in_valid1), .in_ready(in_ready1), .in_word(word),
    .out_valid(out_valid1), .out_ready(out_ready), .out_data(data1), .out_is_index(idx1));

  function automatic int slot_bits(int d);
    case (d)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      5: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic int ref_count(int d, bit rev);
    if (!rev && d >= 6) return 0;
    return 32 / slot_bits(d);
  endfunction

  function automatic logic [24:0] ref_pix(logic [31:0] w, int d, bit xb, bit xp, bit xg,
                                          int m, bit rev, int k);
    int bits, n, pos;
    logic [31:0] ww, raw;
    logic [7:0] r, g, b, t;
    bit sw;
    bits = slot_bits(d);
    n = 32 / bits;
    ww = xb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    pos = (xp && !xb) ? n - 1 - k : k;
    raw = (bits == 32) ? ww : ((ww >> (pos * bits)) & ((32'd1 << bits) - 32'd1));
    if (d <= 3) return {1'b1, 16'h0000, raw[7:0]};
    sw = xg;
    if (d == 5) begin
      r = raw[7:0]; g = raw[15:8]; b = raw[23:16];
    end else if (d == 7 && rev) begin
      r = {raw[3:0], 4'h0}; g = {raw[7:4], 4'h0}; b = {raw[11:8], 4'h0};
    end else if (d == 4 && !rev && m == 3) begin
      b = {raw[4:0], 3'b0}; g = {raw[10:5], 2'b0}; r = {raw[15:11], 3'b0}; sw = 1'b0;
    end else if ((d == 4 && !rev && m != 1) || d == 6) begin
      r = {raw[4:0], 3'b0}; g = {raw[10:5], 2'b0}; b = {raw[15:11], 3'b0};
    end else begin
      r = {raw[4:0], 3'b0}; g = {raw[9:5], 3'b0}; b = {raw[14:10], 3'b0};
    end
    if (sw) begin t = r; r = b; b = t; end
    return {1'b0, r, g, b};
  endfunction

  function automatic string tags(int d, bit xb, bit xp, bit xg, bit rev, bit rnd);
    string s;
    if (d <= 3) s = xb ? "R2/R5" : (xp ? "R2/R4" : "R2/R3");
    else begin
      s = xb ? "R5" : (xp ? "R4" : "R3");
      if (d == 5) s = {s, "/R6"};
      if (xg) s = {s, "/R7"};
      if (!rev && d == 4) s = {s, "/R8"};
      if (rev && d != 5) s = {s, "/R9"};
    end
    if (!rev && d >= 6) s = {s, "/R10"};
    if (rnd) s = {s, "/R11/R13"};
    return s;
  endfunction

  function automatic int ref_lb(int d, int c);
    case (d)
      0: return c / 8;
      1: return c / 4;
      2: return c / 2;
      3: return c;
      5: return c * 4;
      default: return c * 2;
    endcase
  endfunction

  // mode 0: fixed config, 1: config redrawn each cycle, 2: drain
  task automatic step(int sel, int mode);
    bit vin, ir, ov, oi;
    logic [23:0] od;
    logic [24:0] exp_p;
    string t;
    @(negedge clk);
    if (mode == 1) begin
      dep = 3'($urandom); bb = 1'($urandom); bp = 1'($urandom);
      bg = 1'($urandom); mx = 2'($urandom);
    end
    word = $urandom;
    vin = (mode != 2) && ($urandom % 4 != 0);
    in_valid0 = (sel == 0) && vin;
    in_valid1 = (sel == 1) && vin;
    out_ready = (mode == 2) ? 1'b1 : ($urandom % 4 != 0);
    #1;
    ir = sel ? in_ready1 : in_ready0;
    ov = sel ? out_valid1 : out_valid0;
    od = sel ? data1 : data0;
    oi = sel ? idx1 : idx0;
    if (ov && out_ready) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected pixel: actual=%h/%b expected=none", od, oi);
      end else begin
        exp_p = q.pop_front();
        t = tq.pop_front();
        if ({oi, od} !== exp_p) begin
          bad++;
          $display("FAIL %s pixel: actual=%b/%h expected=%b/%h", t, oi, od, exp_p[24], exp_p[23:0]);
        end
      end
    end
    if (vin && ir) begin
      for (int k = 0; k < ref_count(dep, sel == 1); k++) begin
        q.push_back(ref_pix(word, dep, bb, bp, bg, mx, sel == 1, k));
        tq.push_back(tags(dep, bb, bp, bg, sel == 1, mode == 1));
      end
    end
  endtask

  task automatic run_seg(int sel, int d, bit xb, bit xp, bit xg, int m, int n, bit rnd);
    string t;
    dep = 3'(d); bb = xb; bp = xp; bg = xg; mx = 2'(m);
    t = tags(d, xb, xp, xg, sel == 1, rnd);
    for (int i = 0; i < n; i++) step(sel, rnd ? 1 : 0);
    for (int i = 0; i < 40; i++) step(sel, 2);
    total++;
    if (q.size() != 0 || (sel ? out_valid1 : out_valid0)) begin
      bad++;
      $display("FAIL %s drain: actual=%0d pending expected=0", t, q.size());
    end
    q.delete();
    tq.delete();
  endtask

  task automatic check_lb(int d, int c);
    @(negedge clk);
    dep = 3'(d); cols = 12'(c);
    #1;
    total++;
    if (int'(lb0) != ref_lb(d, c) || int'(lb1) != ref_lb(d, c)) begin
      bad++;
      $display("FAIL R12 line bytes depth %0d cols %0d: actual=%0d/%0d expected=%0d",
               d, c, lb0, lb1, ref_lb(d, c));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (out_valid0 || out_valid1 || !in_ready0 || !in_ready1) begin
      bad++;
      $display("FAIL R1 reset: actual=%b%b%b%b expected=0011", out_valid0, out_valid1, in_ready0, in_ready1);
    end
    rst_n = 1'b1;

    for (int d = 0; d < 8; d++) begin
      check_lb(d, 13);
      check_lb(d, 640);
    end
    check_lb(5, 4095);

    for (int d = 0; d < 6; d++) run_seg(0, d, 0, 0, 0, 1, 60, 0);
    run_seg(0, 0, 0, 1, 0, 0, 60, 0);
    run_seg(0, 2, 0, 1, 0, 0, 60, 0);
    run_seg(0, 2, 1, 0, 0, 0, 60, 0);
    run_seg(0, 0, 1, 1, 0, 0, 60, 0);
    run_seg(0, 4, 1, 0, 0, 1, 60, 0);
    run_seg(0, 4, 0, 1, 0, 2, 60, 0);
    run_seg(0, 5, 0, 0, 1, 0, 60, 0);
    for (int m = 0; m < 4; m++) begin
      run_seg(0, 4, 0, 0, 0, m, 60, 0);
      run_seg(0, 4, 0, 0, 1, m, 60, 0);
    end
    run_seg(0, 6, 0, 0, 0, 0, 60, 0);
    run_seg(0, 7, 0, 0, 1, 0, 60, 0);

    run_seg(1, 4, 0, 0, 1, 3, 60, 0);
    run_seg(1, 4, 0, 0, 0, 0, 60, 0);
    run_seg(1, 6, 0, 0, 0, 2, 60, 0);
    run_seg(1, 6, 0, 1, 1, 0, 60, 0);
    run_seg(1, 7, 0, 0, 1, 1, 60, 0);
    run_seg(1, 7, 1, 0, 0, 3, 60, 0);

    run_seg(0, 0, 0, 0, 0, 0, 3000, 1);
    run_seg(1, 0, 0, 0, 0, 0, 3000, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule